// File: doc/BRIEF.md
# Chained-Pixel Serial Memory Readout

This block drains the per-pixel frame memory once an acquisition burst has ended. It drives a single word address that every pixel memory decodes in common, so all pixels present the same slot at once. The words read for that slot are joined into one long chain, word bits and pixel positions in series, and the chain is shifted onto one serial output line at half the core clock rate.

A readout is started by a pulse on `start` together with the count of stored words. The block walks the addresses from 0 upward. Each address's chain goes out most significant bit first, pixel 0 first, and the chains follow each other without a gap. A one-cycle `frame` pulse marks the first bit of every address. After the last address has been sent, `done` rises and stays high until `done_clr`. While a readout runs, and while `done` is high, further start pulses are ignored.

The memory is modelled as a parallel read port. Its data is a combinational function of `mem_addr` and is valid in the same cycle.

Top module: `rdo_serial_readout`

## Requirements
- R1: After reset `done`, `frame` and `sdata` are 0 and `mem_addr` is 0.
- R2: A `start` sampled in idle with a non-zero count sets `mem_addr` to 0 in the next cycle. The first serial bit and `frame` appear in the cycle after that.
- R3: For each address the chain is sent pixel 0 first (pixel p occupies `mem_data[p*WORD_W +: WORD_W]`), and each word goes most significant bit first. Every bit is held on `sdata` for exactly two cycles.
- R4: `frame` is high for exactly one cycle, the first cycle of the first bit of each address, and is low at all other times.
- R5: Addresses 0 to N-1 are visited in increasing order, one step at a time, and always stay below DEPTH. The last bit of one address is followed directly by the first bit of the next.
- R6: `done` rises in the cycle after the second cycle of the last bit. While `done` is high, `frame` and `sdata` are 0, and `done` stays high until `done_clr`.
- R7: `start` has no effect while a readout is running or while `done` is high.
- R8: `done_clr` while `done` is high returns the block to idle. `done` is low in the next cycle, and a new `start` is accepted.
- R9: A `start` with a count of 0 raises `done` in the next cycle, with no `frame` and no serial bits.
- R10: A count greater than DEPTH is treated as DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Readout request pulse |
| nwords | input | CNT_W | Number of stored words to read out |
| done_clr | input | 1 | Clears `done` and returns the block to idle |
| mem_data | input | NPIX*WORD_W | Parallel read data, pixel p at bits [p*WORD_W +: WORD_W] |
| mem_addr | output | ADDR_W | Global word address shared by all pixels |
| sdata | output | 1 | Serial data, one bit every two cycles |
| frame | output | 1 | One-cycle marker on the first bit of each address |
| done | output | 1 | Readout finished, held until cleared |

## Verification
The assertions assume that `start` and `done_clr` are synchronous to `clk`. They also assume that `mem_data` reflects `mem_addr` in the same cycle. The bench meets both: it changes inputs only on falling edges, and its memory model is a combinational function of `mem_addr` and a per-run seed. It holds `done_clr` low during a readout and pulses it only while `done` is high, so the hold-until-clear properties see the sequence the design expects.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } rdo_state_e;
endpackage

// File: rtl/rdo_chain_order.sv
// Reorders the parallel read word so that pixel 0 sits at the top of the chain.
module rdo_chain_order #(
    parameter int NPIX   = 64,
    parameter int WORD_W = 9,
    localparam int NB    = NPIX * WORD_W
) (
    input  logic [NB-1:0] mem_data,
    output logic [NB-1:0] chain
);
    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        assign chain[(NPIX-1-p)*WORD_W +: WORD_W] = mem_data[p*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/rdo_shreg.sv
// Parallel-load shift register, output taken at the top bit.
module rdo_shreg #(
    parameter int NB = 576
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift,
    input  logic [NB-1:0] par_in,
    output logic          msb
);
    logic [NB-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load) begin
            sr_d = par_in;
        end else if (shift) begin
            sr_d = {sr_q[NB-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign msb = sr_q[NB-1];
endmodule

// File: rtl/rdo_ctrl.sv
// Sequencer: address walk, bit counting, half-rate phase, done handling.
module rdo_ctrl
    import rdo_pkg::*;
#(
    parameter int NB     = 576,
    parameter int DEPTH  = 800,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int BC_W   = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  nwords,
    input  logic              done_clr,
    output logic [ADDR_W-1:0] addr,
    output logic              load,
    output logic              shift,
    output logic              streaming,
    output logic              frame,
    output logic              done
);
    typedef struct packed {
        rdo_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [BC_W-1:0]   bitcnt;
        logic              phase;
        logic              more;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic [CNT_W-1:0] n_eff;
    logic             last_bit;
    logic             last_addr;

    assign n_eff     = (nwords > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : nwords;
    assign last_bit  = (c_q.bitcnt == BC_W'(NB - 1));
    assign last_addr = (CNT_W'(c_q.addr) == c_q.cnt - 1'b1);

    always_comb begin
        c_d   = c_q;
        load  = 1'b0;
        shift = 1'b0;
        unique case (c_q.state)
            ST_IDLE: begin
                if (start) begin
                    c_d.addr = '0;
                    c_d.cnt  = n_eff;
                    c_d.state = (n_eff == '0) ? ST_DONE : ST_LOAD;
                end
            end
            ST_LOAD: begin
                load       = 1'b1;
                c_d.state  = ST_SHIFT;
                c_d.bitcnt = '0;
                c_d.phase  = 1'b0;
                c_d.more   = 1'b0;
            end
            ST_SHIFT: begin
                if (!c_q.phase) begin
                    c_d.phase = 1'b1;
                    if (last_bit && !last_addr) begin
                        c_d.addr = c_q.addr + 1'b1;
                        c_d.more = 1'b1;
                    end
                end else begin
                    c_d.phase = 1'b0;
                    if (last_bit) begin
                        if (c_q.more) begin
                            load       = 1'b1;
                            c_d.bitcnt = '0;
                            c_d.more   = 1'b0;
                        end else begin
                            c_d.state = ST_DONE;
                        end
                    end else begin
                        shift      = 1'b1;
                        c_d.bitcnt = c_q.bitcnt + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                if (done_clr) c_d.state = ST_IDLE;
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{state: ST_IDLE, addr: '0, cnt: '0, bitcnt: '0,
                     phase: 1'b0, more: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign addr      = c_q.addr;
    assign streaming = (c_q.state == ST_SHIFT);
    assign frame     = streaming && (c_q.bitcnt == '0) && !c_q.phase;
    assign done      = (c_q.state == ST_DONE);
endmodule

// File: rtl/rdo_serial_readout.sv
module rdo_serial_readout #(
    parameter int NPIX   = 64,
    parameter int WORD_W = 9,
    parameter int DEPTH  = 800,
    localparam int NB     = NPIX * WORD_W,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  nwords,
    input  logic              done_clr,
    input  logic [NB-1:0]     mem_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              sdata,
    output logic              frame,
    output logic              done
);
    logic [NB-1:0] chain;
    logic          load, shift, streaming, msb;

    rdo_chain_order #(.NPIX(NPIX), .WORD_W(WORD_W)) u_order (
        .mem_data (mem_data),
        .chain    (chain)
    );

    rdo_ctrl #(.NB(NB), .DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .nwords    (nwords),
        .done_clr  (done_clr),
        .addr      (mem_addr),
        .load      (load),
        .shift     (shift),
        .streaming (streaming),
        .frame     (frame),
        .done      (done)
    );

    rdo_shreg #(.NB(NB)) u_sr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .shift  (shift),
        .par_in (chain),
        .msb    (msb)
    );

    assign sdata = streaming & msb;
endmodule

// File: rtl/rdo_serial_readout_chk.sv
module rdo_serial_readout_chk #(
    parameter int ADDR_W = 10,
    parameter int DEPTH  = 800
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done_clr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              sdata,
    input logic              frame,
    input logic              done
);
    p_addr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(mem_addr) < DEPTH);

    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr) |->
            (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)) || (mem_addr == '0));

    p_frame_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame |=> !frame);

    p_bit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame |=> $stable(sdata));

    p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!frame && !sdata));

    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_clr) |=> done);

    p_done_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start && !done_clr) |=> (done && !frame));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_clr) |=> !done);
endmodule

bind rdo_serial_readout rdo_serial_readout_chk #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done_clr (done_clr),
    .mem_addr (mem_addr),
    .sdata    (sdata),
    .frame    (frame),
    .done     (done)
);

// File: tb/sim_rdo_serial_readout.sv
`timescale 1ns/1ps
module sim_rdo_serial_readout;
    localparam int NPIX   = 3;
    localparam int W      = 4;
    localparam int DEPTH  = 8;
    localparam int NB     = NPIX * W;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int NVEC   = 6;
    // each entry: {requested word count, data seed}
    localparam logic [7:0] VEC [NVEC] = '{
        {4'd1, 4'd3}, {4'd2, 4'd9}, {4'd5, 4'd0},
        {4'd8, 4'd12}, {4'd13, 4'd5}, {4'd3, 4'd15}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  nwords = '0;
    logic              done_clr = 1'b0;
    logic [NB-1:0]     mem_data;
    logic [ADDR_W-1:0] mem_addr;
    logic              sdata, frame, done;
    int                seed = 0;
    int                checks = 0;
    int                fails = 0;

    always #2 clk = ~clk;

    rdo_serial_readout #(.NPIX(NPIX), .WORD_W(W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .nwords(nwords),
        .done_clr(done_clr), .mem_data(mem_data), .mem_addr(mem_addr),
        .sdata(sdata), .frame(frame), .done(done)
    );

    function automatic logic [W-1:0] word_of(input int a, input int p, input int s);
        int v;
        v = (a * 7 + p * 5 + s) ^ (a * 2);
        return W'(v);
    endfunction

    always_comb begin
        for (int p = 0; p < NPIX; p++)
            mem_data[p*W +: W] = word_of(int'(mem_addr), p, seed);
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_stream(input int nreq, input int s);
        int n;
        seed = s;
        n = (nreq > DEPTH) ? DEPTH : nreq;   // R10 clamp
        nwords = CNT_W'(nreq);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            chk("R9 done after zero count", int'(done), 1);
            chk("R9 no frame", int'(frame), 0);
            return;
        end
        chk("R2 addr reset to 0", int'(mem_addr), 0);
        chk("R2 no frame in load cycle", int'(frame), 0);
        for (int a = 0; a < n; a++) begin
            for (int b = 0; b < NB; b++) begin
                logic [W-1:0] wv;
                int ex;
                wv = word_of(a, b / W, s);
                ex = int'(wv[W - 1 - (b % W)]);
                @(negedge clk);
                chk("R3 bit first cycle", int'(sdata), ex);
                chk("R4 frame on first bit", int'(frame), (b == 0) ? 1 : 0);
                if (b == 0) chk("R5 address sequence", int'(mem_addr), a);
                chk("R6 done low while streaming", int'(done), 0);
                if (a == 0 && b == 1) start = 1'b1;   // R7 request while busy
                @(negedge clk);
                start = 1'b0;
                chk("R3 bit second cycle", int'(sdata), ex);
                chk("R4 frame low second cycle", int'(frame), 0);
            end
        end
        @(negedge clk);
        chk("R6 done after last bit", int'(done), 1);
        chk("R6 sdata quiet when done", int'(sdata), 0);
        chk("R6 frame quiet when done", int'(frame), 0);
    endtask

    task automatic clear_done();
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        chk("R8 done cleared", int'(done), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        int hold_addr;
        repeat (3) @(negedge clk);
        chk("R1 done reset", int'(done), 0);
        chk("R1 frame reset", int'(frame), 0);
        chk("R1 sdata reset", int'(sdata), 0);
        chk("R1 addr reset", int'(mem_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            run_stream(int'(VEC[v][7:4]), int'(VEC[v][3:0]));
            clear_done();
            @(negedge clk);
        end

        // R9 zero count
        run_stream(0, 1);
        clear_done();

        // R7 start ignored while done
        run_stream(2, 6);
        hold_addr = int'(mem_addr);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk("R7 done held despite start", int'(done), 1);
            chk("R7 no frame after ignored start", int'(frame), 0);
            chk("R7 address unchanged", int'(mem_addr), hold_addr);
            @(negedge clk);
        end
        clear_done();
        // R8 a fresh start is accepted after clearing
        run_stream(1, 11);
        clear_done();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule